// File: doc/BRIEF.md
# Quadrature Input Noise Filter

This block cleans up the two phase inputs of an incremental encoder before they reach a position counter. Both raw phases first pass through a two-stage synchronizer. A programmable divider then produces a sample strobe from the system clock. The strobe period is set by an 8-bit value, and each axis instance has its own copy of that value. A phase is passed to the output only after two consecutive strobes have seen the same new level.

Some input activity is too fast for the filter to resolve. Two cases count as such noise: a phase that leaves its accepted level and returns before it is accepted, and both phases moving within one strobe interval. Either case sets a sticky noise flag. The flag stays set until the surrounding logic clears it. One instance of this block serves one axis.

Top module: `qdec_input_filter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `enc_a_flt`, `enc_b_flt` and `noise_err` are 0 after that edge, and the strobe divider restarts from zero.
- R2: The sample strobe fires once every `presc_div + 1` clock cycles. The first strobe after reset comes on the `presc_div + 1`-th rising edge. A filtered output changes only on a strobe edge.
- R3: A filtered output takes a new level only when that level was seen on two consecutive strobes. With `presc_div = 0`, a step on a raw input held steady reaches its output on the 4th rising edge after it is applied. A raw pulse that is seen by only one strobe never reaches the output.
- R4: If a pending change reverts before acceptance, `noise_err` is 1 after that strobe edge. A pending change is a strobe where the synchronized level differs from the accepted level. Reverting means the next strobe sees the accepted level again.
- R5: If both synchronized phases differ from their previous samples at the same strobe, `noise_err` is 1 after that edge.
- R6: `noise_err` stays 1 until `noise_clr` is high at a clock edge with no new noise event. A noise event at the same edge takes priority over the clear.
- R7: A clean quadrature sequence (only one phase changing per several strobes) is passed to the outputs in order, and `noise_err` stays 0.
- R8: Raw inputs pass through two synchronizer flip-flops before the first strobe samples them.
- R9: If `presc_div` is lowered below the current divider count, the next edge is a strobe and the divider restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_a_raw | input | 1 | Raw phase A from the encoder, asynchronous |
| enc_b_raw | input | 1 | Raw phase B from the encoder, asynchronous |
| presc_div | input | 8 | Strobe divider: one strobe per presc_div+1 clocks |
| noise_clr | input | 1 | Clears the sticky noise flag |
| enc_a_flt | output | 1 | Filtered phase A |
| enc_b_flt | output | 1 | Filtered phase B |
| noise_err | output | 1 | Sticky noise flag |

## Verification
A wrong divider count changes the strobe phase. The accepted edges then appear a whole strobe period early or late, and the per-cycle comparison against a reference model catches this within the first transition. If the pending-sample state is corrupted, a filtered output moves after one strobe instead of two, or a single-strobe pulse leaks through. Both show up as an output mismatch in that same strobe interval. A broken noise rule shows as `noise_err` differing from the model. This happens on the edge of the offending strobe, or on the first clear edge if the sticky hold is lost.

// File: rtl/qfilt_pkg.sv
// Shared constants for the quadrature input filter.
// Assumes: one instance per axis, two encoder phases per axis.
package qfilt_pkg;
    localparam int PRESC_W     = 8;   // width of the strobe divider value
    localparam int SYNC_STAGES = 2;   // synchronizer depth for the raw phases
    localparam int NUM_PHASES  = 2;   // phase A and phase B
endpackage

// File: rtl/qfilt_sync.sv
// Multi-stage synchronizer for a bus of asynchronous single-bit inputs.
// Assumes: each bit is independent; STAGES >= 2; reset clears all stages.
module qfilt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // First flop captures the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= d;
    end

    // Remaining flops settle metastability one stage at a time.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage[s] <= '0;
            else        stage[s] <= stage[s-1];
        end

        AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> stage[s] == $past(stage[s-1])); // R8
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/qfilt_tick.sv
// Sample strobe generator: one strobe every div+1 clocks.
// Assumes: div may change at any time; a count at or above the new div
// fires a strobe at once and restarts from zero.
module qfilt_tick #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = (cnt >= div);

    // Count clocks up to the divider value, then wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt == '0); // R9
    AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> cnt == $past(cnt) + 1'b1); // R2
endmodule

// File: rtl/qfilt_chan.sv
// Two-sample acceptance filter for one synchronized phase.
// Assumes: smp is already synchronized; tick is a one-cycle strobe.
// Reports a move (new sample differs from last) and a glitch (a pending
// change reverted to the accepted level) on each strobe.
module qfilt_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic smp,
    output logic out,
    output logic moved,
    output logic glitch
);
    logic prev;
    logic pending;

    assign pending = (prev != out);
    assign moved   = tick && (smp != prev);
    assign glitch  = tick && pending && (smp == out);

    // Keep the last strobe sample; accept a level seen on two strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
            out  <= 1'b0;
        end else if (tick) begin
            prev <= smp;
            if (smp == prev) out <= smp;
        end
    end

    AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(out)); // R2
    AST_TWO_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out) |-> $past(prev) == out); // R3
endmodule

// File: rtl/qfilt_err.sv
// Sticky noise flag for one axis.
// Assumes: moved/glitch are strobe-qualified; a new event beats a clear.
module qfilt_err #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] moved,
    input  logic [N-1:0] glitch,
    input  logic         clr,
    output logic         err
);
    logic event_now;

    assign event_now = (&moved) || (|glitch);

    // Set on a noise event, drop on clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         err <= 1'b0;
        else if (event_now) err <= 1'b1;
        else if (clr)       err <= 1'b0;
    end

    AST_GLITCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|glitch) |=> err); // R4
    AST_BOTH_MOVE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (&moved) |=> err); // R5
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr) |=> err); // R6
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !event_now) |=> !err); // R6
endmodule

// File: rtl/qdec_input_filter.sv
// Per-axis quadrature input noise filter.
// Synchronizes both raw phases, samples them on a programmable strobe,
// accepts levels after two equal strobe samples and flags noise.
// Assumes: one instance per axis, so each axis has its own divider value.
module qdec_input_filter
    import qfilt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enc_a_raw,
    input  logic               enc_b_raw,
    input  logic [PRESC_W-1:0] presc_div,
    input  logic               noise_clr,
    output logic               enc_a_flt,
    output logic               enc_b_flt,
    output logic               noise_err
);
    logic [NUM_PHASES-1:0] raw_bus;
    logic [NUM_PHASES-1:0] sync_bus;
    logic [NUM_PHASES-1:0] flt_bus;
    logic [NUM_PHASES-1:0] moved_bus;
    logic [NUM_PHASES-1:0] glitch_bus;
    logic                  tick;

    assign raw_bus = {enc_b_raw, enc_a_raw};

    qfilt_sync #(.W(NUM_PHASES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bus),
        .q     (sync_bus)
    );

    qfilt_tick #(.W(PRESC_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (presc_div),
        .tick  (tick)
    );

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
        qfilt_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .smp    (sync_bus[p]),
            .out    (flt_bus[p]),
            .moved  (moved_bus[p]),
            .glitch (glitch_bus[p])
        );
    end

    qfilt_err #(.N(NUM_PHASES)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .moved  (moved_bus),
        .glitch (glitch_bus),
        .clr    (noise_clr),
        .err    (noise_err)
    );

    assign enc_a_flt = flt_bus[0];
    assign enc_b_flt = flt_bus[1];

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !noise_err && !enc_a_flt && !enc_b_flt); // R1
endmodule

// File: tb/qdec_input_filter_test.sv
`timescale 1ns/100ps
module qdec_input_filter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_raw = 1'b0, b_raw = 1'b0;
    logic [7:0] div = 8'd0;
    logic       clr = 1'b0;
    logic       a_flt, b_flt, err;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    qdec_input_filter uut (
        .clk(clk), .rst_n(rst_n), .enc_a_raw(a_raw), .enc_b_raw(b_raw),
        .presc_div(div), .noise_clr(clr),
        .enc_a_flt(a_flt), .enc_b_flt(b_flt), .noise_err(err)
    );

    // Reference model built from the requirements.
    logic [1:0] m_s1, m_s2, m_last, m_acc;
    logic [7:0] m_cnt;
    logic       m_err;
    always @(posedge clk) begin
        logic strobe, noisy;
        logic [1:0] mv;
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_last <= 0; m_acc <= 0; m_cnt <= 0; m_err <= 0;
        end else begin
            m_s1 <= {b_raw, a_raw};          // R8 first stage
            m_s2 <= m_s1;                    // R8 second stage
            strobe = (m_cnt >= div);         // R2, R9
            m_cnt <= strobe ? 8'd0 : m_cnt + 8'd1;
            noisy = 1'b0;
            mv = 2'b00;
            if (strobe) begin
                for (int p = 0; p < 2; p++) begin
                    mv[p] = (m_s2[p] != m_last[p]);
                    if (m_last[p] != m_acc[p] && m_s2[p] == m_acc[p]) noisy = 1'b1; // R4
                    if (m_s2[p] == m_last[p]) m_acc[p] <= m_s2[p];                 // R3
                end
                if (mv == 2'b11) noisy = 1'b1;                                        // R5
                m_last <= m_s2;
            end
            if (noisy) m_err <= 1'b1;        // R6 set beats clear
            else if (clr) m_err <= 1'b0;
        end
    end

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: {err,b,a} actual=%b expected=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    logic [15:0] lfsr = 16'hACE1;
    function automatic logic [15:0] step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        a_raw = 1; b_raw = 1;
        edges(3);
        check("R1 reset", {err, b_flt, a_flt}, 3'b000);
        a_raw = 0; b_raw = 0;
        edges(1);
        rst_n = 1'b1;
        edges(6);
        // R3/R8: step with div=0 shows on the 4th edge
        a_raw = 1;
        edges(3);
        check("R8 latency before", {err, b_flt, a_flt}, 3'b000);
        edges(1);
        check("R3 step accepted", {err, b_flt, a_flt}, 3'b001);
        // R3/R4: one-cycle pulse on B is rejected and flags noise
        b_raw = 1;
        edges(1);
        b_raw = 0;
        edges(4);
        check("R4 pulse rejected", {err, b_flt, a_flt}, 3'b101);
        // R6: flag holds without clear
        edges(10);
        check("R6 sticky", {err, b_flt, a_flt}, 3'b101);
        clr = 1'b1;
        edges(1);
        clr = 1'b0;
        check("R6 cleared", {err, b_flt, a_flt}, 3'b001);
        // R5: both phases change together
        a_raw = 0; b_raw = 1;
        edges(4);
        check("R5 both move", {err, b_flt, a_flt}, 3'b110);
        clr = 1'b1;
        edges(1);
        clr = 1'b0;
        check("R6 cleared again", {err, b_flt, a_flt}, 3'b010);
        // R7: clean quadrature sequence with div=2
        div = 8'd2;
        b_raw = 0;
        edges(20);
        check("R7 step1", {err, b_flt, a_flt}, 3'b000);
        a_raw = 1;
        edges(20);
        check("R7 step2", {err, b_flt, a_flt}, 3'b001);
        b_raw = 1;
        edges(20);
        check("R7 step3", {err, b_flt, a_flt}, 3'b011);
        a_raw = 0;
        edges(20);
        check("R7 step4", {err, b_flt, a_flt}, 3'b010);
        // R2/R3/R4/R5/R9: sweep divider values against the model every cycle
        for (int d = 0; d < 6; d++) begin
            div = 8'(d);
            for (int c = 0; c < 1500; c++) begin
                check("R2 R3 R9 sweep", {err, b_flt, a_flt}, {m_err, m_acc[1], m_acc[0]});
                lfsr = step(lfsr);
                if (lfsr[3:0] < 4'd2) a_raw = ~a_raw;
                if (lfsr[7:4] < 4'd2) b_raw = ~b_raw;
                clr = (lfsr[11:8] == 4'd0);
                if (lfsr[15:9] == 7'd0) div = 8'(lfsr[2:0]);
                @(negedge clk);
            end
        end
        // R1: reset mid-run clears state
        rst_n = 1'b0;
        edges(1);
        check("R1 reset mid-run", {err, b_flt, a_flt}, 3'b000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule